// File: doc/BRIEF.md
# Shifter Operand and Carry Unit

This block is a purely combinational 32-bit barrel shifter. It forms the second operand of a data-processing instruction and the carry that the shifter produces alongside it. It reads the instruction word, the values of the shifted register and the amount register, the current instruction address and the current carry flag. It then yields the operand, the shifter carry-out and a flag that marks encodings whose outcome is not defined.

The operand comes in one of four forms. The first is an 8-bit constant rotated right by an even amount. The second is the shifted register moved by a 5-bit constant. The third is the shifted register moved by the low byte of the amount register. The fourth is a one-bit rotate through the carry. The shift kinds are logical left, logical right, arithmetic right and rotate right. A zero amount in the constant-shift form has its own meaning for each kind. Register read, the ALU and flag writeback sit outside the block.

Top module: `shiftop_unit`

## Requirements
- R1: When instruction bit 25 is 1, the operand is instruction bits [7:0], zero-extended and rotated right by twice the value of bits [11:8].
- R2: In the constant-operand form, carry-out equals the incoming carry when bits [11:8] are zero. Otherwise it equals bit 31 of the operand.
- R3: With bit 25 and bit 4 both 0, the register is shifted by the amount in bits [11:7]. Bits [6:5] select the kind: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. For a nonzero amount n, carry-out is the last bit shifted out: Rm[32-n] for a left shift and Rm[n-1] for the right shifts and the rotate.
- R4: A constant logical-left shift by 0 passes the register unchanged and keeps the incoming carry.
- R5: A constant logical-right shift by 0 acts as a shift by 32. The operand is 0 and carry-out is Rm[31].
- R6: A constant arithmetic-right shift by 0 acts as a shift by 32. Every operand bit equals Rm[31], and so does carry-out.
- R7: A constant rotate by 0 is a rotate through the carry. The operand is {carry in, Rm[31:1]} and carry-out is Rm[0].
- R8: In the constant-shift form, a register index of 15 in bits [3:0] makes the shifted value the instruction address plus 8.
- R9: With bit 25 at 0 and bit 4 at 1, the amount is Rs[7:0]. When that byte is 0, the operand is Rm and carry-out is the incoming carry, whatever the kind.
- R10: A register-amount logical shift by exactly 32 gives 0, with carry Rm[0] for a left shift and Rm[31] for a right shift. A shift by more than 32 gives 0 with carry 0.
- R11: A register-amount arithmetic shift by 32 or more fills the operand with Rm[31], and carry-out is Rm[31].
- R12: A register-amount rotate uses Rs[4:0]. If those bits are 0 while Rs[7:0] is nonzero, the operand is Rm and carry-out is Rm[31].
- R13: The unpredictable output is 1 only in the register-amount form, and there exactly when any of the fields [15:12], [19:16], [11:8] or [3:0] equals 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word |
| rmVal | input | 32 | Value of the shifted register |
| rsVal | input | 32 | Value of the amount register |
| pcVal | input | 32 | Address of the current instruction |
| carryIn | input | 1 | Current carry flag |
| operand | output | 32 | Shifted second operand |
| carryOut | output | 1 | Shifter carry-out |
| unpredictable | output | 1 | Encoding with undefined outcome |

## Verification
Several register patterns are used. Values with distinct bits near both ends, such as 0x80000010, separate left from right shifts and arithmetic from logical fills, because the bit that leaves and the bit that fills differ each time. Amounts of 0, 1 to 31, exactly 32 and more than 32 are applied in both the constant and register forms, which exposes confusion between the zero-amount meanings and the saturation rules. Both carry-in polarities are used wherever the carry is kept or fed into the rotate, so a kept carry cannot pass for a constant. The address substitution and each field that can raise the unpredictable flag are exercised one at a time.

// File: rtl/shiftop_pkg.sv
package shiftop_pkg;
  localparam int AMT_W = 6;

  typedef enum logic [2:0] {
    KIND_LSL = 3'd0,
    KIND_LSR = 3'd1,
    KIND_ASR = 3'd2,
    KIND_ROR = 3'd3,
    KIND_RRX = 3'd4
  } shiftKind_e;

  // strobes from the decoder to the datapath
  typedef struct packed {
    logic             selImm;     // source is the 8-bit constant
    logic             selPc;      // source is the instruction address plus offset
    shiftKind_e       kind;
    logic [AMT_W-1:0] amount;     // effective amount, 0..32
    logic             holdCarry;  // carry-out follows the incoming carry
    logic             flushAll;   // result and carry both zero
  } shiftCtrl_t;
endpackage

// File: rtl/shiftop_ctrl.sv
module shiftop_ctrl
  import shiftop_pkg::*;
#(
  parameter int INSTR_W = 32
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic [7:0]         rsLow,
  output shiftCtrl_t         ctrl,
  output logic               unpredictable
);
  localparam int BIT_IMM   = 25;
  localparam int BIT_REG   = 4;
  localparam int FULL_AMT  = 32;
  localparam logic [3:0] PC_IDX = 4'hF;

  logic       immForm;
  logic       regForm;
  logic [1:0] kindField;
  logic [4:0] constAmt;
  logic [3:0] rotField;
  logic [3:0] fldD, fldN, fldS, fldM;

  assign immForm   = instr[BIT_IMM];
  assign regForm   = !instr[BIT_IMM] && instr[BIT_REG];
  assign kindField = instr[6:5];
  assign constAmt  = instr[11:7];
  assign rotField  = instr[11:8];
  assign fldD      = instr[15:12];
  assign fldN      = instr[19:16];
  assign fldS      = instr[11:8];
  assign fldM      = instr[3:0];

  assign unpredictable = regForm &&
    ((fldD == PC_IDX) || (fldN == PC_IDX) || (fldS == PC_IDX) || (fldM == PC_IDX));

  always_comb begin
    ctrl           = '0;
    ctrl.kind      = KIND_LSL;
    if (immForm) begin
      ctrl.selImm    = 1'b1;
      ctrl.kind      = KIND_ROR;
      ctrl.amount    = {1'b0, rotField, 1'b0};
      ctrl.holdCarry = (rotField == 4'd0);
    end else if (!regForm) begin
      ctrl.selPc  = (fldM == PC_IDX);
      ctrl.amount = {1'b0, constAmt};
      unique case (kindField)
        2'b00: begin
          ctrl.kind      = KIND_LSL;
          ctrl.holdCarry = (constAmt == 5'd0);
        end
        2'b01: begin
          ctrl.kind = KIND_LSR;
          if (constAmt == 5'd0) ctrl.amount = AMT_W'(FULL_AMT);
        end
        2'b10: begin
          ctrl.kind = KIND_ASR;
          if (constAmt == 5'd0) ctrl.amount = AMT_W'(FULL_AMT);
        end
        default: begin
          ctrl.kind = (constAmt == 5'd0) ? KIND_RRX : KIND_ROR;
        end
      endcase
    end else begin
      ctrl.holdCarry = (rsLow == 8'd0);
      unique case (kindField)
        2'b00, 2'b01: begin
          ctrl.kind = (kindField == 2'b00) ? KIND_LSL : KIND_LSR;
          if (rsLow > 8'(FULL_AMT)) ctrl.flushAll = 1'b1;
          else                      ctrl.amount   = rsLow[AMT_W-1:0];
        end
        2'b10: begin
          ctrl.kind   = KIND_ASR;
          ctrl.amount = (rsLow >= 8'(FULL_AMT)) ? AMT_W'(FULL_AMT) : rsLow[AMT_W-1:0];
        end
        default: begin
          ctrl.kind   = KIND_ROR;
          ctrl.amount = {1'b0, rsLow[4:0]};
        end
      endcase
    end
  end
endmodule

// File: rtl/shiftop_dp.sv
module shiftop_dp
  import shiftop_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PC_AHEAD = 8
) (
  input  shiftCtrl_t        ctrl,
  input  logic [7:0]        imm8,
  input  logic [DATA_W-1:0] rmVal,
  input  logic [DATA_W-1:0] pcVal,
  input  logic              carryIn,
  output logic [DATA_W-1:0] operand,
  output logic              carryOut
);
  localparam int EXT_W = DATA_W + 1;

  logic [DATA_W-1:0]   src;
  logic [EXT_W-1:0]    leftExt;
  logic [EXT_W-1:0]    rightExt;
  logic [EXT_W-1:0]    arithExt;
  logic [2*DATA_W-1:0] rotExt;
  logic [DATA_W-1:0]   rotLow;
  logic [DATA_W-1:0]   res;
  logic                cBit;

  always_comb begin
    if (ctrl.selImm)     src = {{(DATA_W-8){1'b0}}, imm8};
    else if (ctrl.selPc) src = pcVal + DATA_W'(PC_AHEAD);
    else                 src = rmVal;
  end

  assign leftExt  = {1'b0, src} << ctrl.amount;
  assign rightExt = {src, 1'b0} >> ctrl.amount;
  assign arithExt = $unsigned($signed({src, 1'b0}) >>> ctrl.amount);
  assign rotExt   = {src, src} >> ctrl.amount;
  assign rotLow   = rotExt[DATA_W-1:0];

  always_comb begin
    unique case (ctrl.kind)
      KIND_LSL: begin res = leftExt[DATA_W-1:0];  cBit = leftExt[DATA_W]; end
      KIND_LSR: begin res = rightExt[DATA_W:1];   cBit = rightExt[0];     end
      KIND_ASR: begin res = arithExt[DATA_W:1];   cBit = arithExt[0];     end
      KIND_ROR: begin res = rotLow;               cBit = rotLow[DATA_W-1]; end
      KIND_RRX: begin res = {carryIn, src[DATA_W-1:1]}; cBit = src[0]; end
      default:  begin res = src;                  cBit = carryIn;         end
    endcase
    if (ctrl.flushAll) begin
      res  = '0;
      cBit = 1'b0;
    end
    if (ctrl.holdCarry) cBit = carryIn;
  end

  assign operand  = res;
  assign carryOut = cBit;
endmodule

// File: rtl/shiftop_unit.sv
module shiftop_unit
  import shiftop_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PC_AHEAD = 8
) (
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] rmVal,
  input  logic [DATA_W-1:0] rsVal,
  input  logic [DATA_W-1:0] pcVal,
  input  logic              carryIn,
  output logic [DATA_W-1:0] operand,
  output logic              carryOut,
  output logic              unpredictable
);
  shiftCtrl_t ctrlBus;

  shiftop_ctrl #(.INSTR_W(32)) ctrl_i (
    .instr         (instr),
    .rsLow         (rsVal[7:0]),
    .ctrl          (ctrlBus),
    .unpredictable (unpredictable)
  );

  shiftop_dp #(.DATA_W(DATA_W), .PC_AHEAD(PC_AHEAD)) dp_i (
    .ctrl     (ctrlBus),
    .imm8     (instr[7:0]),
    .rmVal    (rmVal),
    .pcVal    (pcVal),
    .carryIn  (carryIn),
    .operand  (operand),
    .carryOut (carryOut)
  );
endmodule

// File: rtl/shiftop_unit_chk.sv
module shiftop_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic [31:0]       instr,
  input logic [DATA_W-1:0] rmVal,
  input logic [DATA_W-1:0] rsVal,
  input logic [DATA_W-1:0] pcVal,
  input logic              carryIn,
  input logic [DATA_W-1:0] operand,
  input logic              carryOut,
  input logic              unpredictable
);
  logic constShift, regShift, rmIsPc;
  assign constShift = !instr[25] && !instr[4];
  assign regShift   = !instr[25] && instr[4];
  assign rmIsPc     = (instr[3:0] == 4'hF);

  always_comb begin
    if (instr[25] && instr[11:8] == 4'd0)
      AST_IMM_ROT0_CARRY: assert (carryOut == carryIn); // R2
    if (instr[25] && instr[11:8] != 4'd0)
      AST_IMM_ROT_CARRY: assert (carryOut == operand[DATA_W-1]); // R2
    if (constShift && !rmIsPc && instr[11:5] == 7'b0000000)
      AST_LSL0_PASS: assert (operand == rmVal && carryOut == carryIn); // R4
    if (constShift && !rmIsPc && instr[11:5] == 7'b0000001)
      AST_LSR0_FULL: assert (operand == '0 && carryOut == rmVal[DATA_W-1]); // R5
    if (constShift && !rmIsPc && instr[11:5] == 7'b0000010)
      AST_ASR0_FILL: assert (operand == {DATA_W{rmVal[DATA_W-1]}} && carryOut == rmVal[DATA_W-1]); // R6
    if (constShift && !rmIsPc && instr[11:5] == 7'b0000011)
      AST_RRX_FORM: assert (operand == {carryIn, rmVal[DATA_W-1:1]} && carryOut == rmVal[0]); // R7
    if (regShift && rsVal[7:0] == 8'd0)
      AST_REG_ZERO_KEEP: assert (operand == rmVal && carryOut == carryIn); // R9
    if (regShift && instr[6:5] == 2'b10 && rsVal[7:0] >= 8'd32)
      AST_REG_ASR_SAT: assert (operand == {DATA_W{rmVal[DATA_W-1]}} && carryOut == rmVal[DATA_W-1]); // R11
    if (unpredictable)
      AST_UNPRED_FORM: assert (regShift); // R13
  end
endmodule

bind shiftop_unit shiftop_unit_chk #(.DATA_W(DATA_W)) chk_i (
  .instr         (instr),
  .rmVal         (rmVal),
  .rsVal         (rsVal),
  .pcVal         (pcVal),
  .carryIn       (carryIn),
  .operand       (operand),
  .carryOut      (carryOut),
  .unpredictable (unpredictable)
);

// File: tb/shiftop_unit_tb_top.sv
module shiftop_unit_tb_top;
  logic        clk = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] rmVal = '0;
  logic [31:0] rsVal = '0;
  logic [31:0] pcVal = '0;
  logic        carryIn = 1'b0;
  logic [31:0] operand;
  logic        carryOut;
  logic        unpredictable;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  shiftop_unit dut_i (
    .instr(instr), .rmVal(rmVal), .rsVal(rsVal), .pcVal(pcVal), .carryIn(carryIn),
    .operand(operand), .carryOut(carryOut), .unpredictable(unpredictable)
  );

  function automatic logic [31:0] encImm(input logic [3:0] rot, input logic [7:0] k);
    return {4'hE, 3'b001, 4'hD, 1'b0, 4'h0, 4'h1, rot, k};
  endfunction
  function automatic logic [31:0] encConst(input logic [4:0] amt, input logic [1:0] kind,
                                           input logic [3:0] m);
    return {4'hE, 3'b000, 4'hD, 1'b0, 4'h2, 4'h1, amt, kind, 1'b0, m};
  endfunction
  function automatic logic [31:0] encReg(input logic [1:0] kind, input logic [3:0] d,
                                         input logic [3:0] n, input logic [3:0] s,
                                         input logic [3:0] m);
    return {4'hE, 3'b000, 4'hD, 1'b0, n, d, s, 1'b0, kind, 1'b1, m};
  endfunction

  task automatic apply(input logic [31:0] ins, input logic [31:0] rm, input logic [31:0] rs,
                       input logic [31:0] pc, input logic cin);
    @(posedge clk);
    instr = ins; rmVal = rm; rsVal = rs; pcVal = pc; carryIn = cin;
    @(negedge clk);
  endtask

  task automatic expect3(input string req, input logic [31:0] eOp, input logic eC, input logic eU);
    checks++;
    if (operand !== eOp || carryOut !== eC || unpredictable !== eU) begin
      errors++;
      $display("FAIL %s: got op=%h c=%b u=%b expected op=%h c=%b u=%b",
               req, operand, carryOut, unpredictable, eOp, eC, eU);
    end
  endtask

  task automatic t_idle();  // R4 with all-zero word
    apply(32'h0, 32'h1234, 32'h0, 32'h0, 1'b1);
    expect3("R4 idle", 32'h1234, 1'b1, 1'b0);
  endtask

  task automatic t_const_operand();
    apply(encImm(4'd4, 8'hFF), 32'h0, 32'h0, 32'h0, 1'b0);
    expect3("R1 ff ror8", 32'hFF000000, 1'b1, 1'b0);
    apply(encImm(4'd1, 8'h01), 32'h0, 32'h0, 32'h0, 1'b1);
    expect3("R1 01 ror2", 32'h40000000, 1'b0, 1'b0);
    apply(encImm(4'd1, 8'h03), 32'h0, 32'h0, 32'h0, 1'b0);
    expect3("R1 03 ror2", 32'hC0000000, 1'b1, 1'b0);
    apply(encImm(4'd0, 8'h5A), 32'h0, 32'h0, 32'h0, 1'b1);
    expect3("R2 rot0 c1", 32'h0000005A, 1'b1, 1'b0);
    apply(encImm(4'd0, 8'h5A), 32'h0, 32'h0, 32'h0, 1'b0);
    expect3("R2 rot0 c0", 32'h0000005A, 1'b0, 1'b0);
  endtask

  task automatic t_const_kinds();
    apply(encConst(5'd4, 2'b00, 4'h4), 32'h80000010, 0, 0, 1'b1);
    expect3("R3 lsl4", 32'h00000100, 1'b0, 1'b0);
    apply(encConst(5'd1, 2'b00, 4'h4), 32'h80000010, 0, 0, 1'b0);
    expect3("R3 lsl1", 32'h00000020, 1'b1, 1'b0);
    apply(encConst(5'd5, 2'b01, 4'h4), 32'h80000010, 0, 0, 1'b0);
    expect3("R3 lsr5", 32'h04000000, 1'b1, 1'b0);
    apply(encConst(5'd5, 2'b10, 4'h4), 32'h80000010, 0, 0, 1'b0);
    expect3("R3 asr5", 32'hFC000000, 1'b1, 1'b0);
    apply(encConst(5'd5, 2'b11, 4'h4), 32'h80000010, 0, 0, 1'b0);
    expect3("R3 ror5", 32'h84000000, 1'b1, 1'b0);
    apply(encConst(5'd4, 2'b11, 4'h4), 32'h80000010, 0, 0, 1'b1);
    expect3("R3 ror4", 32'h08000001, 1'b0, 1'b0);
  endtask

  task automatic t_zero_meanings();
    apply(encConst(5'd0, 2'b00, 4'h4), 32'hCAFE0001, 0, 0, 1'b0);
    expect3("R4 lsl0", 32'hCAFE0001, 1'b0, 1'b0);
    apply(encConst(5'd0, 2'b01, 4'h4), 32'h80000001, 0, 0, 1'b0);
    expect3("R5 lsr0 msb1", 32'h0, 1'b1, 1'b0);
    apply(encConst(5'd0, 2'b01, 4'h4), 32'h7FFFFFFF, 0, 0, 1'b1);
    expect3("R5 lsr0 msb0", 32'h0, 1'b0, 1'b0);
    apply(encConst(5'd0, 2'b10, 4'h4), 32'h80000000, 0, 0, 1'b0);
    expect3("R6 asr0 neg", 32'hFFFFFFFF, 1'b1, 1'b0);
    apply(encConst(5'd0, 2'b10, 4'h4), 32'h40000000, 0, 0, 1'b1);
    expect3("R6 asr0 pos", 32'h0, 1'b0, 1'b0);
    apply(encConst(5'd0, 2'b11, 4'h4), 32'h00000003, 0, 0, 1'b1);
    expect3("R7 rrx c1", 32'h80000001, 1'b1, 1'b0);
    apply(encConst(5'd0, 2'b11, 4'h4), 32'h00000002, 0, 0, 1'b0);
    expect3("R7 rrx c0", 32'h00000001, 1'b0, 1'b0);
  endtask

  task automatic t_pc_source();
    apply(encConst(5'd0, 2'b00, 4'hF), 32'hDEAD0000, 0, 32'h00001000, 1'b0);
    expect3("R8 pc lsl0", 32'h00001008, 1'b0, 1'b0);
    apply(encConst(5'd1, 2'b00, 4'hF), 32'hDEAD0000, 0, 32'h00001000, 1'b0);
    expect3("R8 pc lsl1", 32'h00002010, 1'b0, 1'b0);
  endtask

  task automatic t_reg_amounts();
    apply(encReg(2'b01, 4'h1, 4'h2, 4'h3, 4'h4), 32'h89ABCDEF, 32'h00000100, 0, 1'b1);
    expect3("R9 lsr zero", 32'h89ABCDEF, 1'b1, 1'b0);
    apply(encReg(2'b11, 4'h1, 4'h2, 4'h3, 4'h4), 32'h89ABCDEF, 32'h00000000, 0, 1'b0);
    expect3("R9 ror zero", 32'h89ABCDEF, 1'b0, 1'b0);
    apply(encReg(2'b00, 4'h1, 4'h2, 4'h3, 4'h4), 32'h000001FF, 32'd8, 0, 1'b1);
    expect3("R10 lsl8", 32'h0001FF00, 1'b0, 1'b0);
    apply(encReg(2'b00, 4'h1, 4'h2, 4'h3, 4'h4), 32'h00000001, 32'd32, 0, 1'b0);
    expect3("R10 lsl32", 32'h0, 1'b1, 1'b0);
    apply(encReg(2'b00, 4'h1, 4'h2, 4'h3, 4'h4), 32'hFFFFFFFF, 32'd33, 0, 1'b1);
    expect3("R10 lsl33", 32'h0, 1'b0, 1'b0);
    apply(encReg(2'b01, 4'h1, 4'h2, 4'h3, 4'h4), 32'h80000000, 32'd32, 0, 1'b0);
    expect3("R10 lsr32", 32'h0, 1'b1, 1'b0);
    apply(encReg(2'b01, 4'h1, 4'h2, 4'h3, 4'h4), 32'hFFFFFFFF, 32'd40, 0, 1'b1);
    expect3("R10 lsr40", 32'h0, 1'b0, 1'b0);
    apply(encReg(2'b01, 4'h1, 4'h2, 4'h3, 4'h4), 32'h00000003, 32'd1, 0, 1'b0);
    expect3("R10 lsr1", 32'h00000001, 1'b1, 1'b0);
    apply(encReg(2'b10, 4'h1, 4'h2, 4'h3, 4'h4), 32'h80000000, 32'd32, 0, 1'b0);
    expect3("R11 asr32", 32'hFFFFFFFF, 1'b1, 1'b0);
    apply(encReg(2'b10, 4'h1, 4'h2, 4'h3, 4'h4), 32'h00007000, 32'd200, 0, 1'b1);
    expect3("R11 asr200", 32'h0, 1'b0, 1'b0);
    apply(encReg(2'b10, 4'h1, 4'h2, 4'h3, 4'h4), 32'h80000000, 32'd31, 0, 1'b1);
    expect3("R11 asr31", 32'hFFFFFFFF, 1'b0, 1'b0);
    apply(encReg(2'b11, 4'h1, 4'h2, 4'h3, 4'h4), 32'h80000001, 32'h00000020, 0, 1'b0);
    expect3("R12 ror32", 32'h80000001, 1'b1, 1'b0);
    apply(encReg(2'b11, 4'h1, 4'h2, 4'h3, 4'h4), 32'h0000000F, 32'h00000024, 0, 1'b0);
    expect3("R12 ror4", 32'hF0000000, 1'b1, 1'b0);
  endtask

  task automatic t_unpredictable();
    apply(encReg(2'b00, 4'hF, 4'h2, 4'h3, 4'h4), 32'h5, 32'd1, 0, 1'b0);
    expect3("R13 rd15", 32'hA, 1'b0, 1'b1);
    apply(encReg(2'b00, 4'h1, 4'hF, 4'h3, 4'h4), 32'h5, 32'd1, 0, 1'b0);
    expect3("R13 rn15", 32'hA, 1'b0, 1'b1);
    apply(encReg(2'b00, 4'h1, 4'h2, 4'hF, 4'h4), 32'h5, 32'd1, 0, 1'b0);
    expect3("R13 rs15", 32'hA, 1'b0, 1'b1);
    apply(encReg(2'b00, 4'h1, 4'h2, 4'h3, 4'hF), 32'h5, 32'd1, 0, 1'b0);
    expect3("R13 rm15", 32'hA, 1'b0, 1'b1);
    apply(encReg(2'b00, 4'h1, 4'h2, 4'h3, 4'h4), 32'h5, 32'd1, 0, 1'b0);
    expect3("R13 clean", 32'hA, 1'b0, 1'b0);
    apply(encImm(4'hF, 8'hFF) | 32'h0000F000, 32'h0, 32'h0, 32'h0, 1'b0);
    expect3("R13 imm form", 32'h000003FC, 1'b0, 1'b0);
  endtask

  initial begin
    t_idle();
    t_const_operand();
    t_const_kinds();
    t_zero_meanings();
    t_pc_source();
    t_reg_amounts();
    t_unpredictable();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got no completion expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule